// File: doc/BRIEF.md
# Packet-Broadcast Clock Tick Source

This block is the timing source of a machine whose units talk over a shared packet network rather than over a common clock wire. It puts the system clock onto the network as a stream of packets, all broadcast to every unit. The packets alternate between a tick, which stands for a rising edge of the system clock, and a tock, which stands for a falling edge. Each packet names the clock generator as its sending unit type. The address, data and status fields, which the clock does not own, are sent as zeros.

A programmable half-period value sets how many core cycles pass between packets. The packet leaves on a valid/ready bus. When the network stalls the bus, the pending packet waits and nothing is skipped, so the tick/tock order is never broken. Dropping the enable input stops the stream once the packet already offered has been taken. The next enable starts again from a tick.

Top module: `tick_packet_source`

## Requirements
- R1: After reset `pkt_valid` is 0 and every packet field is 0.
- R2: Let N be `half_period`, or 1 when `half_period` is 0. With `enable` high and no packet pending, `pkt_valid` rises after exactly N rising clock edges.
- R3: A packet is taken on an edge where `pkt_valid` and `pkt_ready` are both high. After that edge `pkt_valid` is low, and it rises again after exactly N further edges.
- R4: Bit 0 of `pkt_ctrl` is 1 for a tick and 0 for a tock. The first packet after reset, or after a spell of `enable` low with nothing pending, is a tick. Each packet that follows carries the opposite value of the one before it.
- R5: Every offered packet has `pkt_src` = 4'h1, the clock generator type code. Its `pkt_addr`, `pkt_data` and `pkt_status` are 0, and bits 7:1 of `pkt_ctrl` are 0.
- R6: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid` stays high and every field holds its value. No packet is lost.
- R7: If `enable` falls while a packet is pending, that packet is still offered until it is taken. After that, `pkt_valid` stays low for as long as `enable` is low.
- R8: Dropping `enable` while waiting clears the wait count. After `enable` returns, the first packet appears after a full N edges and is a tick.
- R9: While `pkt_valid` is low, all packet fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Allows new packets to be generated |
| half_period | input | 16 | Core cycles between packets (0 acts as 1) |
| pkt_valid | output | 1 | A packet is offered |
| pkt_ready | input | 1 | The network takes the offered packet |
| pkt_src | output | 4 | Sending unit type |
| pkt_addr | output | 16 | Address field, always null |
| pkt_data | output | 8 | Data field, always null |
| pkt_ctrl | output | 8 | Control field; bit 0 is tick (1) or tock (0) |
| pkt_status | output | 4 | Status field, always null |

## Verification
Every output comes straight from a register, so a result is visible in the half cycle after the edge that causes it. The bench drives inputs and samples outputs on falling edges. After an enable or a handshake it counts falling edges, and the first packet must be seen on exactly the Nth one. A handshake is made by raising ready on a falling edge. Valid must then read low on the next falling edge, and during a stall the fields must read the same on every falling edge. The time from a dropped enable to a silent bus is one edge, the one that takes the pending packet. After that the bench checks several falling edges with no packet.

// File: rtl/tick_packet_source.sv
module tick_packet_source #(
  parameter int DIV_W  = 16,
  parameter int SRC_W  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTRL_W = 8,
  parameter int STAT_W = 4,
  parameter int unsigned SRC_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  half_period,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [SRC_W-1:0]  pkt_src,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic [DATA_W-1:0] pkt_data,
  output logic [CTRL_W-1:0] pkt_ctrl,
  output logic [STAT_W-1:0] pkt_status
);

  logic [DIV_W-1:0] cnt;
  logic             valid_q;
  logic             tick_q;

  wire [DIV_W-1:0] limit = (half_period == '0) ? DIV_W'(1) : half_period;
  wire             due   = (cnt >= limit - DIV_W'(1));
  wire             take  = valid_q && pkt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      valid_q <= 1'b0;
      tick_q  <= 1'b1;
    end else if (take) begin
      valid_q <= 1'b0;
      tick_q  <= ~tick_q;
    end else if (!valid_q) begin
      if (!enable) begin
        cnt    <= '0;
        tick_q <= 1'b1;
      end else if (due) begin
        cnt     <= '0;
        valid_q <= 1'b1;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  assign pkt_valid  = valid_q;
  assign pkt_src    = valid_q ? SRC_W'(SRC_ID) : '0;
  assign pkt_addr   = '0;
  assign pkt_data   = '0;
  assign pkt_status = '0;
  assign pkt_ctrl   = {{(CTRL_W-1){1'b0}}, valid_q & tick_q};

endmodule

module tick_packet_source_chk #(
  parameter int SRC_W  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTRL_W = 8,
  parameter int STAT_W = 4,
  parameter int unsigned SRC_ID = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              pkt_valid,
  input logic              pkt_ready,
  input logic [SRC_W-1:0]  pkt_src,
  input logic [ADDR_W-1:0] pkt_addr,
  input logic [DATA_W-1:0] pkt_data,
  input logic [CTRL_W-1:0] pkt_ctrl,
  input logic [STAT_W-1:0] pkt_status
);

  logic exp_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     exp_tick <= 1'b1;
    else if (pkt_valid && pkt_ready) exp_tick <= ~exp_tick;
    else if (!pkt_valid && !enable)  exp_tick <= 1'b1;
  end

  p_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_src == SRC_W'(SRC_ID)) && (pkt_addr == '0) && (pkt_data == '0)
                  && (pkt_status == '0) && (pkt_ctrl[CTRL_W-1:1] == '0));

  p_idle_null_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> (pkt_src == '0) && (pkt_ctrl == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> pkt_valid && $stable(pkt_ctrl) && $stable(pkt_src));

  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |=> !pkt_valid);

  p_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_ctrl[0] == exp_tick));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !pkt_valid) |=> !pkt_valid);

endmodule

bind tick_packet_source tick_packet_source_chk #(
  .SRC_W(SRC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CTRL_W(CTRL_W), .STAT_W(STAT_W), .SRC_ID(SRC_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready), .pkt_src(pkt_src), .pkt_addr(pkt_addr),
  .pkt_data(pkt_data), .pkt_ctrl(pkt_ctrl), .pkt_status(pkt_status)
);

// File: tb/tick_packet_source_tb.sv
`timescale 1ns/1ps
module tick_packet_source_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] half_period = 16'd1;
  logic        pkt_ready = 1'b0;
  logic        pkt_valid;
  logic [3:0]  pkt_src;
  logic [15:0] pkt_addr;
  logic [7:0]  pkt_data;
  logic [7:0]  pkt_ctrl;
  logic [3:0]  pkt_status;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tick_packet_source u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_period(half_period),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_src(pkt_src),
    .pkt_addr(pkt_addr), .pkt_data(pkt_data), .pkt_ctrl(pkt_ctrl),
    .pkt_status(pkt_status)
  );

  // {half_period, stall cycles, expected wait N}
  localparam logic [47:0] VEC [0:5] = '{
    {16'd1,  16'd0, 16'd1},
    {16'd3,  16'd2, 16'd3},
    {16'd0,  16'd1, 16'd1},
    {16'd7,  16'd0, 16'd7},
    {16'd2,  16'd5, 16'd2},
    {16'd16, 16'd3, 16'd16}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid(output int edges);
    edges = 0;
    do begin
      @(negedge clk);
      edges++;
    end while (!pkt_valid && edges < 70000);
  endtask

  task automatic chk_fields(input bit tick, input string req);
    chk(pkt_ctrl == {7'd0, tick}, req, pkt_ctrl, {7'd0, tick});
    chk(pkt_src == 4'h1 && pkt_addr == 0 && pkt_data == 0 && pkt_status == 0,
        "R5 null fields/source", {pkt_src, pkt_addr, pkt_data, pkt_status}, 32'h1000_0000);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int edges;
    repeat (3) @(negedge clk);
    chk(pkt_valid == 1'b0, "R1 valid in reset", pkt_valid, 0);
    chk(pkt_ctrl == 0 && pkt_src == 0, "R1 fields in reset", {pkt_src, pkt_ctrl}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R1 valid after reset", pkt_valid, 0);

    for (int v = 0; v < 6; v++) begin
      logic [15:0] n;
      logic [15:0] stall;
      logic [7:0]  held;
      half_period = VEC[v][47:32];
      stall = VEC[v][31:16];
      n = VEC[v][15:0];
      pkt_ready = 1'b0;
      enable = 1'b1;
      wait_valid(edges);
      chk(edges == int'(n), "R2 first packet delay", edges, n);
      chk_fields(1'b1, "R4 first packet is tick");
      held = pkt_ctrl;
      for (int s = 0; s < int'(stall); s++) begin
        @(negedge clk);
        chk(pkt_valid && pkt_ctrl == held, "R6 held under stall", {pkt_valid, pkt_ctrl}, {1'b1, held});
      end
      pkt_ready = 1'b1;
      @(negedge clk);
      chk(pkt_valid == 1'b0, "R3 valid drops after handshake", pkt_valid, 0);
      chk(pkt_ctrl == 0 && pkt_src == 0, "R9 idle fields null", {pkt_src, pkt_ctrl}, 0);
      wait_valid(edges);
      pkt_ready = 1'b0;
      chk(edges == int'(n), "R3 gap after handshake", edges, n);
      chk_fields(1'b0, "R4 second packet is tock");
      enable = 1'b0;
      @(negedge clk);
      chk(pkt_valid == 1'b1 && pkt_ctrl[0] == 1'b0, "R7 pending kept after disable", {pkt_valid, pkt_ctrl[0]}, 2'b10);
      pkt_ready = 1'b1;
      @(negedge clk);
      pkt_ready = 1'b0;
      for (int q = 0; q < 20; q++) begin
        @(negedge clk);
        if (pkt_valid) break;
      end
      chk(pkt_valid == 1'b0, "R7 silent while disabled", pkt_valid, 0);
    end

    half_period = 16'd5;
    enable = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(pkt_valid == 1'b0, "R8 no packet while disabled", pkt_valid, 0);
    enable = 1'b1;
    wait_valid(edges);
    chk(edges == 5, "R8 full wait after re-enable", edges, 5);
    chk_fields(1'b1, "R8 restart is tick");
    pkt_ready = 1'b1;
    @(negedge clk);
    wait_valid(edges);
    chk(pkt_ctrl[0] == 1'b0, "R4 tock follows tick", pkt_ctrl[0], 0);
    enable = 1'b0;
    @(negedge clk);
    pkt_ready = 1'b0;

    half_period = 16'd4;
    enable = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R1 reset mid-run", pkt_valid, 0);
    rst_n = 1'b1;
    wait_valid(edges);
    chk(edges == 4, "R2 delay after reset", edges, 4);
    chk_fields(1'b1, "R4 tick after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule